// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Model

A synthesizable slave that answers on an SPI bus the way a small serial EEPROM does. It holds a 512-byte array organised as 64 pages of 8 bytes. A read streams bytes from any starting address. A write gathers up to one page of data and commits it when chip select is released. A status register reports a busy flag, a write-enable latch, three block-protect bits and a write-protect-enable bit. The last three are plain storage that software may set.

The bus runs in mode 0: the clock idles low, MOSI is sampled on the rising edge, MISO changes after the falling edge, and chip select is active low. The SPI pins are oversampled by the system clock, so SCLK must stay well below the system clock rate. A nine-bit address is formed from opcode bit 3, which is address bit 8, and one address byte. After a write commit, the busy flag stays set for the number of system clocks given on an input port. This delay stands in for the internal program cycle.

Top module: `spi_eeprom_model`

## Requirements
- R1: After reset the status register reads 0x00 and every array byte reads 0xFF.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1), and opcode 0x04 clears it.
- R3: Opcodes 0x02 (write) and 0x03 (read) are followed by one address byte. Opcode bit 3 is address bit 8, so 0x0A and 0x0B reach bytes 0x100 to 0x1FF.
- R4: A write or status-write opcode issued while the write-enable latch is clear changes nothing.
- R5: The data bytes of one write fill consecutive addresses. Address bits 2:0 wrap and bits 8:3 stay fixed, so the write stays inside its 8-byte page.
- R6: A write commits only if chip select rises after a whole number of bytes with at least one data byte. Otherwise neither the array nor the latch changes.
- R7: A committed write clears the write-enable latch and sets status bit 0 for the number of system clocks on `busy_delay`. While that bit is set, every opcode except 0x05 is ignored.
- R8: A read returns the byte at the address, then the following bytes with the address incrementing, wrapping from 0x1FF to 0x000, until chip select rises.
- R9: Opcode 0x05 returns the live status byte in every following byte slot. Layout: bit 0 busy, bit 1 write-enable latch, bits 4:2 block-protect, bit 7 write-protect enable, bits 6:5 zero.
- R10: Opcode 0x01 with the latch set takes the first data byte and updates only status bits 7 and 4:2. It commits and starts busy as in R6 and R7.
- R11: MISO changes only after a sampled SCLK falling edge. The MISO output enable is high only while chip select is low.
- R12: Any opcode other than those listed above is ignored, and so are the bytes that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_delay | input | DELAY_W | Length in system clocks of the post-commit busy time |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out of the slave |
| spi_miso_oe | output | 1 | Drive enable for MISO; low means high impedance |

## Verification
The hardest states to reach from the pins are a command that arrives inside the busy window and a transaction cut off in the middle of a byte. The bench sets a long busy delay, so a status poll and a latch-set opcode both land while busy is set. It then checks after the window that the latch stayed clear. Aborted writes are made by shifting a few extra bits after a data byte, and by releasing chip select straight after the address byte. Each is followed by a status read and an array read-back. A full sweep writes every page with an arithmetic pattern and reads all 512 bytes in one stream across the top-to-bottom wrap.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    localparam int ADDR_W     = 9;
    localparam int PAGE_W     = 3;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PAGE_IDX_W = ADDR_W - PAGE_W;

    localparam logic [7:0] OP_SR_WRITE  = 8'h01;
    localparam logic [7:0] OP_ARR_WRITE = 8'h02;
    localparam logic [7:0] OP_ARR_READ  = 8'h03;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_SR_READ   = 8'h05;
    localparam logic [7:0] OP_LATCH_SET = 8'h06;

    typedef enum logic [2:0] {
        ST_SKIP,
        ST_CMD,
        ST_RADDR,
        ST_RDATA,
        ST_STAT,
        ST_WADDR,
        ST_WDATA,
        ST_WSTAT
    } ee_state_e;

endpackage

// File: rtl/spi_eeprom_pins.sv
module spi_eeprom_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_start,
    output logic cs_end,
    output logic cs_act,
    output logic mosi_s
);

    typedef struct packed {
        logic sclk;
        logic sclk_prev;
        logic cs_n;
        logic cs_n_prev;
        logic mosi;
    } pin_t;

    pin_t q, d;

    always_comb begin
        d           = q;
        d.sclk      = sclk_in;
        d.sclk_prev = q.sclk;
        d.cs_n      = cs_n_in;
        d.cs_n_prev = q.cs_n;
        d.mosi      = mosi_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sclk: 1'b0, sclk_prev: 1'b0, cs_n: 1'b1, cs_n_prev: 1'b1, mosi: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sclk_rise = q.sclk & ~q.sclk_prev;
    assign sclk_fall = ~q.sclk & q.sclk_prev;
    assign cs_start  = q.cs_n_prev & ~q.cs_n;
    assign cs_end    = ~q.cs_n_prev & q.cs_n;
    assign cs_act    = ~q.cs_n;
    assign mosi_s    = q.mosi;

endmodule

// File: rtl/spi_eeprom_array.sv
module spi_eeprom_array
    import spi_eeprom_pkg::*;
#(
    parameter logic [7:0] FILL_BYTE = 8'hFF
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [7:0]                          rd_data,
    input  logic                                wr_commit,
    input  logic [PAGE_IDX_W-1:0]               wr_page,
    input  logic [PAGE_BYTES-1:0]               wr_mask,
    input  logic [PAGE_BYTES-1:0][7:0]          wr_data
);

    logic [DEPTH-1:0][7:0] mem_q;
    logic [DEPTH-1:0][7:0] mem_d;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] CELL = ADDR_W'(g);
        logic hit;
        assign hit = wr_commit
                   && (wr_page == CELL[ADDR_W-1:PAGE_W])
                   && wr_mask[CELL[PAGE_W-1:0]];
        assign mem_d[g] = hit ? wr_data[CELL[PAGE_W-1:0]] : mem_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= {DEPTH{FILL_BYTE}};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
    import spi_eeprom_pkg::*;
#(
    parameter int DELAY_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_rise,
    input  logic                       sclk_fall,
    input  logic                       cs_start,
    input  logic                       cs_end,
    input  logic                       cs_act,
    input  logic                       mosi,
    input  logic [DELAY_W-1:0]         busy_delay,
    input  logic [7:0]                 rd_data,
    output logic [ADDR_W-1:0]          rd_addr,
    output logic                       wr_commit,
    output logic [PAGE_IDX_W-1:0]      wr_page,
    output logic [PAGE_BYTES-1:0]      wr_mask,
    output logic [PAGE_BYTES-1:0][7:0] wr_data,
    output logic                       miso
);

    typedef struct packed {
        ee_state_e                  state;
        logic [2:0]                 bit_cnt;
        logic [6:0]                 sh_in;
        logic [ADDR_W-1:0]          addr;
        logic [7:0]                 tx;
        logic                       miso;
        logic                       wel;
        logic                       wpen;
        logic [2:0]                 bp;
        logic [DELAY_W-1:0]         busy_cnt;
        logic [PAGE_BYTES-1:0][7:0] wbuf;
        logic [PAGE_BYTES-1:0]      wmask;
        logic                       got;
        logic                       sr_wpen;
        logic [2:0]                 sr_bp;
        logic                       commit;
    } ctrl_t;

    ctrl_t q, d;

    logic       busy;
    logic [7:0] byte_in;
    logic [7:0] op_base;
    logic [7:0] status;

    assign busy    = (q.busy_cnt != '0);
    assign byte_in = {q.sh_in, mosi};
    assign op_base = {byte_in[7:4], 1'b0, byte_in[2:0]};
    assign status  = {q.wpen, 2'b00, q.bp, q.wel, busy};

    always_comb begin
        if (q.state == ST_RADDR) begin
            rd_addr = {q.addr[ADDR_W-1], byte_in};
        end else begin
            rd_addr = q.addr;
        end
    end

    always_comb begin
        d        = q;
        d.commit = 1'b0;
        if (busy) begin
            d.busy_cnt = q.busy_cnt - 1'b1;
        end

        if (cs_start) begin
            d.state   = ST_CMD;
            d.bit_cnt = '0;
            d.wmask   = '0;
            d.got     = 1'b0;
        end else if (cs_end) begin
            if ((q.bit_cnt == '0) && q.got
                && ((q.state == ST_WDATA) || (q.state == ST_WSTAT))) begin
                if (q.state == ST_WDATA) begin
                    d.commit = 1'b1;
                end else begin
                    d.wpen = q.sr_wpen;
                    d.bp   = q.sr_bp;
                end
                d.wel      = 1'b0;
                d.busy_cnt = busy_delay;
            end
            d.state = ST_SKIP;
        end else if (cs_act) begin
            if (sclk_rise) begin
                d.sh_in   = byte_in[6:0];
                d.bit_cnt = q.bit_cnt + 1'b1;
                if (q.bit_cnt == 3'd7) begin
                    unique case (q.state)
                        ST_CMD: begin
                            d.state = ST_SKIP;
                            if (byte_in == OP_SR_READ) begin
                                d.state = ST_STAT;
                                d.tx    = status;
                            end else if (!busy) begin
                                if (byte_in == OP_LATCH_SET) begin
                                    d.wel = 1'b1;
                                end else if (byte_in == OP_LATCH_CLR) begin
                                    d.wel = 1'b0;
                                end else if (byte_in == OP_SR_WRITE) begin
                                    if (q.wel) d.state = ST_WSTAT;
                                end else if (op_base == OP_ARR_READ) begin
                                    d.state            = ST_RADDR;
                                    d.addr[ADDR_W-1]   = byte_in[3];
                                end else if (op_base == OP_ARR_WRITE) begin
                                    if (q.wel) begin
                                        d.state          = ST_WADDR;
                                        d.addr[ADDR_W-1] = byte_in[3];
                                    end
                                end
                            end
                        end
                        ST_RADDR, ST_RDATA: begin
                            d.state = ST_RDATA;
                            d.tx    = rd_data;
                            d.addr  = rd_addr + 1'b1;
                        end
                        ST_STAT: begin
                            d.tx = status;
                        end
                        ST_WADDR: begin
                            d.addr[7:0] = byte_in;
                            d.state     = ST_WDATA;
                        end
                        ST_WDATA: begin
                            d.wbuf[q.addr[PAGE_W-1:0]]  = byte_in;
                            d.wmask[q.addr[PAGE_W-1:0]] = 1'b1;
                            d.addr[PAGE_W-1:0]          = q.addr[PAGE_W-1:0] + 1'b1;
                            d.got                       = 1'b1;
                        end
                        ST_WSTAT: begin
                            if (!q.got) begin
                                d.sr_wpen = byte_in[7];
                                d.sr_bp   = byte_in[4:2];
                                d.got     = 1'b1;
                            end
                        end
                        default: begin
                        end
                    endcase
                end
            end else if (sclk_fall) begin
                d.miso = q.tx[7];
                d.tx   = {q.tx[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_SKIP;
        end else begin
            q <= d;
        end
    end

    assign wr_commit = q.commit;
    assign wr_page   = q.addr[ADDR_W-1:PAGE_W];
    assign wr_mask   = q.wmask;
    assign wr_data   = q.wbuf;
    assign miso      = q.miso;

    logic                  miso_q_w;
    logic                  wel_q_w;
    logic [DELAY_W-1:0]    busy_cnt_w;
    logic [PAGE_IDX_W-1:0] page_w;
    logic                  in_wdata;
    assign miso_q_w   = q.miso;
    assign wel_q_w    = q.wel;
    assign busy_cnt_w = q.busy_cnt;
    assign page_w     = q.addr[ADDR_W-1:PAGE_W];
    assign in_wdata   = (q.state == ST_WDATA);

    assert_commit_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(wel_q_w));

    assert_page_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wdata && $past(in_wdata)) |-> $stable(page_w));

    assert_busy_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt_w != '0) |=> (busy_cnt_w == $past(busy_cnt_w) - 1'b1));

    assert_latch_rise_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q_w) |-> ($past(busy_cnt_w) == '0));

    assert_miso_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso_q_w) |-> $past(sclk_fall));

endmodule

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model
    import spi_eeprom_pkg::*;
#(
    parameter int         DELAY_W   = 16,
    parameter logic [7:0] FILL_BYTE = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DELAY_W-1:0] busy_delay,
    input  logic               spi_sclk,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    output logic               spi_miso,
    output logic               spi_miso_oe
);

    logic sclk_rise, sclk_fall, cs_start, cs_end, cs_act, mosi_s;
    logic [ADDR_W-1:0]          rd_addr;
    logic [7:0]                 rd_data;
    logic                       wr_commit;
    logic [PAGE_IDX_W-1:0]      wr_page;
    logic [PAGE_BYTES-1:0]      wr_mask;
    logic [PAGE_BYTES-1:0][7:0] wr_data;

    spi_eeprom_pins u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (spi_sclk),
        .cs_n_in   (spi_cs_n),
        .mosi_in   (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s)
    );

    spi_eeprom_ctrl #(.DELAY_W(DELAY_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .cs_start   (cs_start),
        .cs_end     (cs_end),
        .cs_act     (cs_act),
        .mosi       (mosi_s),
        .busy_delay (busy_delay),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wr_commit  (wr_commit),
        .wr_page    (wr_page),
        .wr_mask    (wr_mask),
        .wr_data    (wr_data),
        .miso       (spi_miso)
    );

    spi_eeprom_array #(.FILL_BYTE(FILL_BYTE)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_commit (wr_commit),
        .wr_page   (wr_page),
        .wr_mask   (wr_mask),
        .wr_data   (wr_data)
    );

    assign spi_miso_oe = cs_act;

endmodule

// File: tb/spi_eeprom_model_tb.sv
`timescale 1ns/1ps
module spi_eeprom_model_tb;

    localparam int H  = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] busy_delay;
    logic          sclk, cs_n, mosi;
    logic          miso, miso_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] txb [0:599];
    logic [7:0] rxb [0:599];
    logic       oe_mid;
    logic [7:0] sr;

    always #2 clk = ~clk;

    spi_eeprom_model #(.DELAY_W(DW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_delay  (busy_delay),
        .spi_sclk    (sclk),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7) ^ (a >> 4));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic spi_txn(input int nb, input int xb);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nb * 8 + xb; i++) begin
            mosi = txb[i / 8][7 - (i % 8)];
            sclk = 1'b0;
            repeat (H) @(negedge clk);
            if (i == 0) oe_mid = miso_oe;
            rxb[i / 8][7 - (i % 8)] = miso;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic op_only(input logic [7:0] b);
        txb[0] = b;
        spi_txn(1, 0);
    endtask

    task automatic read_sr(output logic [7:0] s);
        txb[0] = 8'h05;
        txb[1] = 8'h00;
        spi_txn(2, 0);
        s = rxb[1];
    endtask

    task automatic rd(input int a, input int n);
        txb[0] = 8'h03 | 8'(((a >> 8) & 1) << 3);
        txb[1] = 8'(a);
        for (int i = 0; i < n; i++) txb[2 + i] = 8'h00;
        spi_txn(n + 2, 0);
    endtask

    task automatic wr(input int a, input int n);
        txb[0] = 8'h02 | 8'(((a >> 8) & 1) << 3);
        txb[1] = 8'(a);
        spi_txn(n + 2, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        busy_delay = 16'd500;
        oe_mid = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11: output enable low while deselected
        chk("R11 oe idle", int'(miso_oe), 0);
        // R1: reset status
        read_sr(sr);
        chk("R1 status after reset", sr, 8'h00);
        chk("R11 oe during select", int'(oe_mid), 1);
        chk("R11 oe after release", int'(miso_oe), 0);
        // R1: array filled
        rd(16'h010, 4);
        for (int i = 0; i < 4; i++) chk("R1 array reset byte", rxb[2 + i], 8'hFF);

        // R4: write with latch clear
        txb[2] = 8'h55;
        wr(16'h020, 1);
        repeat (520) @(negedge clk);
        rd(16'h020, 1);
        chk("R4 write without latch", rxb[2], 8'hFF);
        read_sr(sr);
        chk("R4 no busy after ignored write", sr, 8'h00);

        // R2: latch set and clear
        op_only(8'h06);
        read_sr(sr);
        chk("R2 latch set", sr, 8'h02);
        op_only(8'h04);
        read_sr(sr);
        chk("R2 latch cleared", sr, 8'h00);

        // R10: status write without latch
        txb[0] = 8'h01; txb[1] = 8'hFF;
        spi_txn(2, 0);
        read_sr(sr);
        chk("R10 status write without latch", sr, 8'h00);
        // R10 + R7: status write with latch
        op_only(8'h06);
        txb[0] = 8'h01; txb[1] = 8'hFF;
        spi_txn(2, 0);
        read_sr(sr);
        chk("R7 busy set, latch cleared", sr, 8'h9D);
        op_only(8'h06);   // R7: must be ignored while busy
        repeat (520) @(negedge clk);
        read_sr(sr);
        chk("R10 masked update, R7 latch-set ignored while busy", sr, 8'h9C);
        op_only(8'h06);
        txb[0] = 8'h01; txb[1] = 8'h00;
        spi_txn(2, 0);
        repeat (520) @(negedge clk);
        read_sr(sr);
        chk("R10 status cleared", sr, 8'h00);

        // R5: page wrap
        op_only(8'h06);
        txb[2] = 8'h11; txb[3] = 8'h22; txb[4] = 8'h33; txb[5] = 8'h44;
        wr(16'h046, 4);
        repeat (520) @(negedge clk);
        rd(16'h040, 8);
        chk("R5 wrap byte 0x40", rxb[2], 8'h33);
        chk("R5 wrap byte 0x41", rxb[3], 8'h44);
        for (int i = 2; i < 6; i++) chk("R5 untouched in page", rxb[2 + i], 8'hFF);
        chk("R5 byte 0x46", rxb[8], 8'h11);
        chk("R5 byte 0x47", rxb[9], 8'h22);
        rd(16'h048, 1);
        chk("R5 next page untouched", rxb[2], 8'hFF);

        // R3: upper half via opcode bit 3
        op_only(8'h06);
        txb[2] = 8'hA5;
        wr(16'h146, 1);
        repeat (520) @(negedge clk);
        rd(16'h146, 1);
        chk("R3 upper half write/read", rxb[2], 8'hA5);
        rd(16'h046, 1);
        chk("R3 lower half unchanged", rxb[2], 8'h11);

        // R6: partial byte abort
        op_only(8'h06);
        txb[0] = 8'h02; txb[1] = 8'h80; txb[2] = 8'h5A; txb[3] = 8'hFF;
        spi_txn(3, 3);
        read_sr(sr);
        chk("R6 partial byte keeps latch, no busy", sr, 8'h02);
        rd(16'h080, 1);
        chk("R6 partial byte no write", rxb[2], 8'hFF);
        txb[0] = 8'h02; txb[1] = 8'h81;
        spi_txn(2, 0);
        read_sr(sr);
        chk("R6 no data byte keeps latch", sr, 8'h02);

        // R12: unknown opcode with latch set
        txb[0] = 8'h12; txb[1] = 8'h80; txb[2] = 8'h77;
        spi_txn(3, 0);
        read_sr(sr);
        chk("R12 unknown opcode no effect on status", sr, 8'h02);
        rd(16'h080, 1);
        chk("R12 unknown opcode no write", rxb[2], 8'hFF);

        // R9: repeated status bytes
        txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
        spi_txn(4, 0);
        for (int i = 1; i < 4; i++) chk("R9 status repeats", rxb[i], 8'h02);
        op_only(8'h04);

        // R8: full sweep and wrapping stream
        busy_delay = 16'd16;
        repeat (4) @(negedge clk);
        for (int p = 0; p < 64; p++) begin
            op_only(8'h06);
            for (int k = 0; k < 8; k++) txb[2 + k] = pat(p * 8 + k);
            wr(p * 8, 8);
            repeat (24) @(negedge clk);
        end
        rd(16'h1F8, 514);
        for (int i = 0; i < 514; i++)
            chk("R8 stream byte", rxb[2 + i], pat((16'h1F8 + i) % 512));
        read_sr(sr);
        chk("R7 latch cleared after sweep", sr, 8'h00);

        done = 1;
        summary();
        $finish;
    end

endmodule